// File: doc/BRIEF.md
# Multi-Channel Scaler Counter

This block counts detector pulses as a function of time. A rising edge on the start input launches one sweep: a run of consecutive time bins, each lasting a programmable number of clock cycles. During every bin the block counts rising edges seen on the signal input. At the close of each bin it stores that count in a bin memory. After the sweep, a host reads the memory through a simple registered read port. The active output is high for exactly the duration of the sweep. The done output is raised when the last bin has been stored.

Both pulse inputs are asynchronous to the clock. Each passes through a two-stage synchronizer, and an edge is recognised when the previous sample was 0 and the current sample is 1. A pulse therefore has to be high for at least one clock period to be seen, and the fastest countable rate is one edge every two cycles. Configuration is captured at the moment a sweep launches. An accumulate bit decides whether a sweep adds its counts to the stored values or replaces them. A clear command empties the whole memory in a single cycle.

Top module: `mcs_scaler`

## Requirements
- R1: After reset, active and done are 0 and every bin reads as 0.
- R2: A rising edge on startIn (two-flop synchronized, edge = previous sample 0 and current sample 1) while idle raises active. Active then stays high for exactly (cfgLastBin+1)*(cfgWidthM1+1) cycles.
- R3: Bin b covers sweep cycles b*W to (b+1)*W-1, where W = cfgWidthM1+1. Bin b receives the number of synchronized rising edges of sigIn that fall in those cycles. A level held high counts once.
- R4: An edge detected in the first cycle of a bin is counted in that bin, not in the bin before it. With W=1 every cycle is its own bin.
- R5: Per-bin counts saturate at 2^CNT_W-1. Accumulated sums saturate at 2^CNT_W-1 and never wrap.
- R6: A start edge arriving while active is high is ignored. The sweep length and bin contents are unchanged.
- R7: Done rises in the same cycle that active falls at the end of a sweep. Done stays high until the next sweep launches, and is never high together with active.
- R8: With the accumulate bit low at launch, each bin of the sweep is overwritten with that sweep's count.
- R9: With the accumulate bit high at launch, each bin becomes the saturating sum of its previous stored value and the new count.
- R10: A clearReq pulse while active is low makes every bin read 0 from the next cycle on. A clearReq while active is high has no effect.
- R11: rdData shows the stored value of bin rdAddr one clock after rdAddr is presented.
- R12: cfgWidthM1, cfgLastBin and cfgAccum are captured at launch. Changing them during a sweep has no effect on that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Asynchronous start trigger, rising edge active |
| sigIn | input | 1 | Asynchronous pulse input to be counted |
| cfgWidthM1 | input | BW_W | Bin length in cycles minus one |
| cfgLastBin | input | BIN_AW | Index of the final bin (bin count minus one) |
| cfgAccum | input | 1 | 1 = add counts to stored bins, 0 = overwrite |
| clearReq | input | 1 | Synchronous request to zero the bin memory |
| rdAddr | input | BIN_AW | Bin index to read |
| rdData | output | CNT_W | Stored count of the addressed bin, one cycle later |
| active | output | 1 | High while a sweep is running |
| done | output | 1 | Set when the final bin is stored, cleared on launch |

## Verification
The hardest cases to reach are a signal edge landing exactly on the first cycle of a new bin, and a start edge or clear request arriving in the middle of a sweep. The stimulus uses one-cycle bins driven by a signal that toggles every cycle, so every bin boundary coincides with a possible edge. It re-pulses start and clear part way through long sweeps. Saturation is reached quickly by building the bench with an 8-bit counter width, a long single bin of toggling input, and repeated accumulating sweeps.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  // Strobes passed from the sweep controller to the counting datapath
  typedef struct packed {
    logic sweepStart; // launch cycle: reset the running bin count
    logic countEn;    // sweep is running: count signal edges
    logic binEnd;     // last cycle of the current bin: store the count
    logic accumMode;  // add to the stored value instead of overwriting
    logic clearMem;   // zero the whole memory
  } mcsStrobe_t;
endpackage

// File: rtl/mcs_edge_sync.sv
module mcs_edge_sync #(
  parameter int N_CH = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N_CH-1:0] rawIn,
  output logic [N_CH-1:0] risePulse
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic meta, syncd, prevQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta  <= 1'b0;
        syncd <= 1'b0;
        prevQ <= 1'b0;
      end else begin
        meta  <= rawIn[ch];
        syncd <= meta;
        prevQ <= syncd;
      end
    end
    assign risePulse[ch] = syncd & ~prevQ;
  end
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
#(
  parameter int BIN_AW = 10,
  parameter int BW_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEdge,
  input  logic              clearReq,
  input  logic [BW_W-1:0]   cfgWidthM1,
  input  logic [BIN_AW-1:0] cfgLastBin,
  input  logic              cfgAccum,
  output mcsStrobe_t        strobe,
  output logic [BIN_AW-1:0] binAddr,
  output logic              active,
  output logic              done
);
  logic [BW_W-1:0]   cycCnt, widthQ;
  logic [BIN_AW-1:0] binIdx, lastQ;
  logic              accumQ, activeQ, doneQ;
  logic              launch, binLast, sweepLast;

  assign launch    = startEdge & ~activeQ;
  assign binLast   = activeQ && (cycCnt == widthQ);
  assign sweepLast = binLast && (binIdx == lastQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      doneQ   <= 1'b0;
      cycCnt  <= '0;
      binIdx  <= '0;
      widthQ  <= '0;
      lastQ   <= '0;
      accumQ  <= 1'b0;
    end else if (launch) begin
      activeQ <= 1'b1;
      doneQ   <= 1'b0;
      cycCnt  <= '0;
      binIdx  <= '0;
      widthQ  <= cfgWidthM1;
      lastQ   <= cfgLastBin;
      accumQ  <= cfgAccum;
    end else if (activeQ) begin
      if (binLast) begin
        cycCnt <= '0;
        if (sweepLast) begin
          activeQ <= 1'b0;
          doneQ   <= 1'b1;
        end else begin
          binIdx <= binIdx + 1'b1;
        end
      end else begin
        cycCnt <= cycCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.sweepStart = launch;
    strobe.countEn    = activeQ;
    strobe.binEnd     = binLast;
    strobe.accumMode  = accumQ;
    strobe.clearMem   = clearReq & ~activeQ;
  end

  assign binAddr = binIdx;
  assign active  = activeQ;
  assign done    = doneQ;
endmodule

// File: rtl/mcs_datapath.sv
module mcs_datapath
  import mcs_pkg::*;
#(
  parameter int BIN_AW = 10,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mcsStrobe_t        strobe,
  input  logic [BIN_AW-1:0] binAddr,
  input  logic              sigEdge,
  input  logic [BIN_AW-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic [CNT_W-1:0]  binCount
);
  localparam int               DEPTH   = 1 << BIN_AW;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] valid;
  logic [CNT_W-1:0] binSum, oldVal, wrVal;
  logic [CNT_W:0]   accSum;
  logic             inc;

  assign inc    = strobe.countEn & sigEdge;
  assign binSum = (inc && binCount != CNT_MAX) ? binCount + CNT_W'(1) : binCount;
  assign oldVal = valid[binAddr] ? mem[binAddr] : '0;
  assign accSum = {1'b0, oldVal} + {1'b0, binSum};

  always_comb begin
    if (!strobe.accumMode)   wrVal = binSum;
    else if (accSum[CNT_W])  wrVal = CNT_MAX;
    else                     wrVal = accSum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 binCount <= '0;
    else if (strobe.sweepStart || strobe.binEnd) binCount <= '0;
    else if (strobe.countEn)                   binCount <= binSum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                valid <= '0;
    else if (strobe.clearMem) valid <= '0;
    else if (strobe.binEnd)   valid[binAddr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.binEnd) mem[binAddr] <= wrVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= valid[rdAddr] ? mem[rdAddr] : '0;
  end
endmodule

// File: rtl/mcs_scaler.sv
module mcs_scaler
  import mcs_pkg::*;
#(
  parameter int BIN_AW = 10,
  parameter int CNT_W  = 16,
  parameter int BW_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              sigIn,
  input  logic [BW_W-1:0]   cfgWidthM1,
  input  logic [BIN_AW-1:0] cfgLastBin,
  input  logic              cfgAccum,
  input  logic              clearReq,
  input  logic [BIN_AW-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              active,
  output logic              done
);
  logic [1:0]        rises;
  logic              startEdge, sigEdge;
  mcsStrobe_t        strobe;
  logic [BIN_AW-1:0] binAddr;
  logic [CNT_W-1:0]  binCount;

  mcs_edge_sync #(.N_CH(2)) i_sync (
    .clk(clk), .rstN(rstN), .rawIn({sigIn, startIn}), .risePulse(rises)
  );
  assign startEdge = rises[0];
  assign sigEdge   = rises[1];

  mcs_ctrl #(.BIN_AW(BIN_AW), .BW_W(BW_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startEdge(startEdge), .clearReq(clearReq),
    .cfgWidthM1(cfgWidthM1), .cfgLastBin(cfgLastBin), .cfgAccum(cfgAccum),
    .strobe(strobe), .binAddr(binAddr), .active(active), .done(done)
  );

  mcs_datapath #(.BIN_AW(BIN_AW), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .binAddr(binAddr),
    .sigEdge(sigEdge), .rdAddr(rdAddr), .rdData(rdData), .binCount(binCount)
  );
endmodule

// File: rtl/mcs_scaler_chk.sv
module mcs_scaler_chk #(
  parameter int BIN_AW = 10,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              active,
  input logic              done,
  input logic              startEdge,
  input logic              sweepStart,
  input logic              countEn,
  input logic              binEnd,
  input logic [BIN_AW-1:0] binAddr,
  input logic [CNT_W-1:0]  binCount
);
  p_active_done_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(active && done));

  p_launch_from_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> $past(startEdge));

  p_end_sets_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> (done && $past(binEnd)));

  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (active && startEdge && !binEnd) |=> (active && binAddr == $past(binAddr)));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !binEnd && !sweepStart) |=> (binCount >= $past(binCount)));

  p_bin_steady_r12: assert property (@(posedge clk) disable iff (!rstN)
    (active && !binEnd) |=> $stable(binAddr));
endmodule

bind mcs_scaler mcs_scaler_chk #(.BIN_AW(BIN_AW), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .active(active), .done(done), .startEdge(startEdge),
  .sweepStart(strobe.sweepStart), .countEn(strobe.countEn),
  .binEnd(strobe.binEnd), .binAddr(binAddr), .binCount(binCount)
);

// File: tb/test_mcs_scaler.sv
module test_mcs_scaler;
  localparam int AW   = 10;
  localparam int CW   = 8;
  localparam int BW   = 16;
  localparam int NBIN = 1 << AW;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startIn = 1'b0, sigIn = 1'b0, cfgAccum = 1'b0, clearReq = 1'b0;
  logic [BW-1:0] cfgWidthM1 = '0;
  logic [AW-1:0] cfgLastBin = '0, rdAddr = '0;
  logic [CW-1:0] rdData;
  logic          active, done;

  int checks = 0, errors = 0;
  int patMode = 0, cyc = 0, activeCnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int mAct = 0, mDone = 0, mT = 0, mW = 1, mNB = 1, mAcc = 0;
  int mCnt [NBIN];
  int mMem [NBIN];
  bit s1 = 0, s2 = 0, s3 = 0, g1 = 0, g2 = 0, g3 = 0;

  always #4 clk = ~clk;

  mcs_scaler #(.BIN_AW(AW), .CNT_W(CW), .BW_W(BW)) i_mcs_scaler (
    .clk(clk), .rstN(rstN), .startIn(startIn), .sigIn(sigIn),
    .cfgWidthM1(cfgWidthM1), .cfgLastBin(cfgLastBin), .cfgAccum(cfgAccum),
    .clearReq(clearReq), .rdAddr(rdAddr), .rdData(rdData),
    .active(active), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // signal pattern driver
  always @(negedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (patMode)
      1: sigIn <= cyc[0];
      2: sigIn <= lfsr[0];
      3: sigIn <= (cyc % 3 == 0);
      4: sigIn <= 1'b1;
      default: sigIn <= 1'b0;
    endcase
  end

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (rstN) begin
      bit stE, sgE;
      int oldAct;
      stE = s2 & ~s3;
      sgE = g2 & ~g3;
      s3 = s2; s2 = s1; s1 = startIn;
      g3 = g2; g2 = g1; g1 = sigIn;
      oldAct = mAct;
      if (clearReq && !oldAct)
        for (int i = 0; i < NBIN; i++) mMem[i] = 0;
      if (oldAct) begin
        int b;
        b = mT / mW;
        if (sgE && mCnt[b] < CMAX) mCnt[b]++;
        mT++;
        if (mT == mW * mNB) begin
          for (int i = 0; i < mNB; i++) begin
            if (mAcc) mMem[i] = (mMem[i] + mCnt[i] > CMAX) ? CMAX : mMem[i] + mCnt[i];
            else      mMem[i] = mCnt[i];
          end
          mAct = 0;
          mDone = 1;
        end
      end else if (stE) begin
        mAct = 1; mDone = 0; mT = 0;
        mW = int'(cfgWidthM1) + 1;
        mNB = int'(cfgLastBin) + 1;
        mAcc = int'(cfgAccum);
        for (int i = 0; i < NBIN; i++) mCnt[i] = 0;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(active == mAct[0], "R2 active", int'(active), mAct);
      check(done == mDone[0], "R7 done", int'(done), mDone);
      if (active) activeCnt <= activeCnt + 1;
    end
  end

  task automatic pulseStart();
    @(negedge clk) startIn = 1'b1;
    @(negedge clk) startIn = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk) clearReq = 1'b1;
    @(negedge clk) clearReq = 1'b0;
  endtask

  task automatic finishSweep();
    repeat (4) @(negedge clk);
    while (active) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runSweep(input int wm1, input int last, input int acc, input int pat);
    cfgWidthM1 = BW'(wm1);
    cfgLastBin = AW'(last);
    cfgAccum = acc[0];
    patMode = pat;
    activeCnt = 0;
    pulseStart();
    finishSweep();
    patMode = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic readBin(input int a, input string tag);
    @(negedge clk) rdAddr = AW'(a);
    @(negedge clk);
    check(int'(rdData) == mMem[a], tag, int'(rdData), mMem[a]);
  endtask

  initial begin
    for (int i = 0; i < NBIN; i++) begin mMem[i] = 0; mCnt[i] = 0; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(active == 1'b0, "R1 active", int'(active), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    readBin(0, "R1 bin0");
    readBin(NBIN - 1, "R1 top bin");

    // R2 R3 R8 random pulses, 5 bins of 4 cycles
    runSweep(3, 4, 0, 2);
    check(activeCnt == 20, "R2 sweep length", activeCnt, 20);
    for (int i = 0; i < 6; i++) readBin(i, "R3 R8 random bins");

    // R3 level held high counts once
    cfgWidthM1 = 9; cfgLastBin = 2; cfgAccum = 0; activeCnt = 0;
    pulseStart();
    patMode = 4;
    finishSweep();
    patMode = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) readBin(i, "R3 held high");

    // R4 one-cycle bins with toggling input, then two-cycle bins
    runSweep(0, 7, 0, 1);
    for (int i = 0; i < 8; i++) readBin(i, "R4 boundary W1");
    runSweep(1, 5, 0, 1);
    for (int i = 0; i < 6; i++) readBin(i, "R4 boundary W2");

    // R6 start during sweep ignored
    cfgWidthM1 = 4; cfgLastBin = 9; cfgAccum = 0; patMode = 3; activeCnt = 0;
    pulseStart();
    repeat (15) @(negedge clk);
    pulseStart();
    finishSweep();
    patMode = 0;
    check(activeCnt == 50, "R6 sweep length", activeCnt, 50);
    for (int i = 0; i < 10; i++) readBin(i, "R6 bins");

    // R12 config changes mid-sweep ignored
    cfgWidthM1 = 5; cfgLastBin = 3; cfgAccum = 0; patMode = 2; activeCnt = 0;
    pulseStart();
    repeat (6) @(negedge clk);
    cfgWidthM1 = 1; cfgLastBin = 9; cfgAccum = 1;
    finishSweep();
    patMode = 0;
    check(activeCnt == 24, "R12 sweep length", activeCnt, 24);
    for (int i = 0; i < 4; i++) readBin(i, "R12 bins");

    // R9 accumulate over two sweeps
    runSweep(5, 3, 1, 2);
    runSweep(5, 3, 1, 3);
    for (int i = 0; i < 5; i++) readBin(i, "R9 accumulate");

    // R5 saturation within a bin, then through accumulation
    runSweep(599, 0, 0, 1);
    readBin(0, "R5 bin saturates");
    check(int'(rdData) == CMAX, "R5 max value", int'(rdData), CMAX);
    runSweep(199, 1, 1, 1);
    runSweep(199, 1, 1, 1);
    runSweep(199, 1, 1, 1);
    readBin(0, "R5 accum sat bin0");
    readBin(1, "R5 accum sat bin1");

    // R11 back-to-back reads of distinct bins
    runSweep(2, 3, 0, 3);
    @(negedge clk) rdAddr = 0;
    @(negedge clk);
    check(int'(rdData) == mMem[0], "R11 read a", int'(rdData), mMem[0]);
    rdAddr = 2;
    @(negedge clk);
    check(int'(rdData) == mMem[2], "R11 read b", int'(rdData), mMem[2]);

    // R10 clear during sweep ignored, clear while idle empties memory
    cfgWidthM1 = 3; cfgLastBin = 3; cfgAccum = 1; patMode = 1; activeCnt = 0;
    pulseStart();
    repeat (6) @(negedge clk);
    pulseClear();
    finishSweep();
    patMode = 0;
    for (int i = 0; i < 4; i++) readBin(i, "R10 clear ignored");
    check(mMem[0] != 0, "R10 nonzero before clear", mMem[0], 1);
    pulseClear();
    for (int i = 0; i < 4; i++) readBin(i, "R10 cleared");
    check(int'(rdData) == 0, "R10 zero", int'(rdData), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule